// File: doc/BRIEF.md
# Trigger Conditioner and Strobe Generator

This block takes an asynchronous trigger line, brings it into the clock domain, and filters out glitches. A level change counts only after it has stayed stable for a programmable number of cycles. The active edge direction is selectable. When a qualified edge arrives and the block is armed and idle, it does three things:

- latches the free-running timebase value that belongs to the moment the edge first reached the clock domain;
- pulses a timestamp-valid marker;
- starts a timer that drives a strobe pulse with a programmable delay and width.

Qualified edges that arrive while the block is disarmed or busy are counted as dropped. Short excursions towards the active level are counted as rejected.

Configuration is loaded through a single write strobe. That write loads the edge polarity, the arm flag, the stability threshold, the delay and the width. The delay and width are read back on dedicated outputs. The timer copies the delay and width when it starts, so a write during a pulse does not disturb the pulse in progress. All counters wrap at their width.

Top module: `trig_strobe_gen`

## Requirements
- R1: A change of the synchronized input level is taken only after it has been seen on `min_stable` consecutive clock cycles; a `min_stable` of 0 is treated as 1.
- R2: A change towards the active level that reverts before reaching `min_stable` cycles increments `reject_cnt` by one and produces no timestamp, no accept and no strobe.
- R3: `cfg_pol` = 0 makes the rising edge (input going to 1) the active edge; `cfg_pol` = 1 makes the falling edge active; a qualified edge in the other direction has no effect on any counter or output.
- R4: For each accepted trigger, `ts_valid` is high for exactly one cycle and `ts_value` equals the `timebase` value sampled at the first clock edge at which the input's new level was captured (the synchronizer and filter latency are subtracted, assuming the timebase advances by one per cycle).
- R5: `accept_cnt` increments by exactly one per accepted trigger, in the same cycle that `ts_valid` is high.
- R6: The strobe rises `D` cycles after the cycle in which `ts_valid` is high, where `D` is the programmed delay; with `D` = 0 the strobe rises in that same cycle, which is the cycle after acceptance.
- R7: The strobe stays high for exactly `W` cycles, `W` being the programmed width; `W` = 0 produces no strobe and leaves `busy` low.
- R8: `delay_rb` and `width_rb` show the values written with `cfg_we`, from the cycle after the write.
- R9: `busy` is high from the cycle `ts_valid` is high until the strobe's last high cycle, and the strobe is never high while `busy` is low; `armed` reflects the written arm flag.
- R10: A qualified active edge that arrives while `armed` is low or `busy` is high increments `drop_cnt` by one, and leaves `accept_cnt`, `ts_valid` and the strobe untouched.
- R11: After reset all counters, readbacks, `ts_value`, `ts_valid`, `strobe`, `busy` and `armed` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_in | input | 1 | Asynchronous trigger line |
| timebase | input | TS_W | Free-running time count |
| cfg_we | input | 1 | Loads all configuration fields below |
| cfg_pol | input | 1 | Edge select: 0 rising, 1 falling |
| cfg_arm | input | 1 | Arm flag |
| cfg_min_stable | input | FLT_W | Minimum stable cycles for a level change |
| cfg_delay | input | TMR_W | Strobe delay in cycles |
| cfg_width | input | TMR_W | Strobe width in cycles |
| delay_rb | output | TMR_W | Readback of programmed delay |
| width_rb | output | TMR_W | Readback of programmed width |
| ts_value | output | TS_W | Timestamp of last accepted trigger |
| ts_valid | output | 1 | One-cycle marker for a new timestamp |
| strobe | output | 1 | Strobe pulse |
| armed | output | 1 | Arm status |
| busy | output | 1 | Delay or pulse in progress |
| accept_cnt | output | CNT_W | Accepted triggers |
| reject_cnt | output | CNT_W | Glitches rejected by the filter |
| drop_cnt | output | CNT_W | Qualified edges dropped while disarmed or busy |

## Verification
The bench builds the block with the following parameters:

- `TS_W` = 16;
- `CNT_W` = 8;
- `TMR_W` = 8;
- `FLT_W` = 4;
- two synchronizer stages.

The 4-bit threshold keeps the zero-means-one case and the pulse-length-equals-threshold boundary within a few cycles. The 8-bit delay and width let a long delay be combined with a short one, so that a second trigger can land inside the busy window. The timebase is a bench counter that advances once per clock. This makes the expected timestamp exactly the count seen when the pulse was driven, so any error in the latency compensation shows up as a numeric mismatch.

// File: rtl/trig_strobe_pkg.sv
package trig_strobe_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_WAIT  = 2'd1,
    TMR_PULSE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/trig_edge_filter.sv
module trig_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 4,
  parameter int TS_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_async,
  input  logic             pol,
  input  logic [FLT_W-1:0] min_stable,
  input  logic [TS_W-1:0]  timebase,
  output logic             edge_evt,
  output logic             rej_evt,
  output logic [TS_W-1:0]  edge_ts
);
  localparam logic [TS_W-1:0] LAT_FIX = TS_W'(SYNC_STAGES - 1);

  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= trig_async;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  logic             sync_lvl, act_lvl, differs;
  logic             filt_q, filt_d;
  logic [FLT_W-1:0] cnt_q, cnt_d, m_eff;
  logic [FLT_W:0]   cnt_inc;
  logic             edge_q, edge_d, rej_q, rej_d;
  logic [TS_W-1:0]  ts_q, ts_d;

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    act_lvl = ~pol;
    m_eff   = (min_stable == '0) ? FLT_W'(1) : min_stable;
    differs = sync_lvl ^ filt_q;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    filt_d  = filt_q;
    cnt_d   = cnt_q;
    edge_d  = 1'b0;
    rej_d   = 1'b0;
    ts_d    = ts_q;
    if (differs) begin
      if (cnt_inc >= {1'b0, m_eff}) begin
        filt_d = sync_lvl;
        cnt_d  = '0;
        if (sync_lvl == act_lvl) begin
          edge_d = 1'b1;
          ts_d   = timebase - LAT_FIX - TS_W'(m_eff);
        end
      end else begin
        cnt_d = cnt_inc[FLT_W-1:0];
      end
    end else if (cnt_q != '0) begin
      cnt_d = '0;
      if (~filt_q == act_lvl) rej_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      edge_q <= 1'b0;
      rej_q  <= 1'b0;
      ts_q   <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
      rej_q  <= rej_d;
      ts_q   <= ts_d;
    end
  end

  assign edge_evt = edge_q;
  assign rej_evt  = rej_q;
  assign edge_ts  = ts_q;
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import trig_strobe_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMR_W-1:0] dly,
  input  logic [TMR_W-1:0] wid,
  output logic             strobe,
  output logic             busy
);
  tmr_state_e       st_q, st_d;
  logic [TMR_W-1:0] cnt_q, cnt_d, wid_q, wid_d;
  logic             str_q, str_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    wid_d = wid_q;
    str_d = str_q;
    unique case (st_q)
      TMR_IDLE: begin
        if (start && wid != '0) begin
          wid_d = wid;
          if (dly == '0) begin
            st_d  = TMR_PULSE;
            cnt_d = wid;
            str_d = 1'b1;
          end else begin
            st_d  = TMR_WAIT;
            cnt_d = dly;
          end
        end
      end
      TMR_WAIT: begin
        if (cnt_q == TMR_W'(1)) begin
          st_d  = TMR_PULSE;
          cnt_d = wid_q;
          str_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      TMR_PULSE: begin
        if (cnt_q == TMR_W'(1)) begin
          st_d  = TMR_IDLE;
          cnt_d = '0;
          str_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d  = TMR_IDLE;
        str_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
      wid_q <= '0;
      str_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wid_q <= wid_d;
      str_q <= str_d;
    end
  end

  assign strobe = str_q;
  assign busy   = (st_q != TMR_IDLE);
endmodule

// File: rtl/trig_strobe_gen.sv
module trig_strobe_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 48,
  parameter int CNT_W       = 16,
  parameter int TMR_W       = 16,
  parameter int FLT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [TS_W-1:0]  timebase,
  input  logic             cfg_we,
  input  logic             cfg_pol,
  input  logic             cfg_arm,
  input  logic [FLT_W-1:0] cfg_min_stable,
  input  logic [TMR_W-1:0] cfg_delay,
  input  logic [TMR_W-1:0] cfg_width,
  output logic [TMR_W-1:0] delay_rb,
  output logic [TMR_W-1:0] width_rb,
  output logic [TS_W-1:0]  ts_value,
  output logic             ts_valid,
  output logic             strobe,
  output logic             armed,
  output logic             busy,
  output logic [CNT_W-1:0] accept_cnt,
  output logic [CNT_W-1:0] reject_cnt,
  output logic [CNT_W-1:0] drop_cnt
);
  logic             pol_q, arm_q;
  logic [FLT_W-1:0] min_q;
  logic [TMR_W-1:0] dly_q, wid_q;
  logic             edge_evt, rej_evt, tmr_busy, take;
  logic [TS_W-1:0]  edge_ts, ts_q, ts_d;
  logic             tsv_q, tsv_d;
  logic [CNT_W-1:0] acc_q, acc_d, rej_q, rej_d, drp_q, drp_d;

  trig_edge_filter #(
    .SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W), .TS_W(TS_W)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .trig_async(trig_in), .pol(pol_q),
    .min_stable(min_q), .timebase(timebase),
    .edge_evt(edge_evt), .rej_evt(rej_evt), .edge_ts(edge_ts)
  );

  strobe_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(take), .dly(dly_q), .wid(wid_q),
    .strobe(strobe), .busy(tmr_busy)
  );

  always_comb begin
    take  = edge_evt & arm_q & ~tmr_busy;
    ts_d  = take ? edge_ts : ts_q;
    tsv_d = take;
    acc_d = take ? acc_q + 1'b1 : acc_q;
    drp_d = (edge_evt && !take) ? drp_q + 1'b1 : drp_q;
    rej_d = rej_evt ? rej_q + 1'b1 : rej_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      arm_q <= 1'b0;
      min_q <= '0;
      dly_q <= '0;
      wid_q <= '0;
    end else if (cfg_we) begin
      pol_q <= cfg_pol;
      arm_q <= cfg_arm;
      min_q <= cfg_min_stable;
      dly_q <= cfg_delay;
      wid_q <= cfg_width;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q  <= '0;
      tsv_q <= 1'b0;
      acc_q <= '0;
      rej_q <= '0;
      drp_q <= '0;
    end else begin
      ts_q  <= ts_d;
      tsv_q <= tsv_d;
      acc_q <= acc_d;
      rej_q <= rej_d;
      drp_q <= drp_d;
    end
  end

  assign delay_rb   = dly_q;
  assign width_rb   = wid_q;
  assign ts_value   = ts_q;
  assign ts_valid   = tsv_q;
  assign armed      = arm_q;
  assign busy       = tmr_busy;
  assign accept_cnt = acc_q;
  assign reject_cnt = rej_q;
  assign drop_cnt   = drp_q;
endmodule

// File: rtl/trig_strobe_chk.sv
module trig_strobe_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             busy,
  input logic             strobe,
  input logic             ts_valid,
  input logic [CNT_W-1:0] accept_cnt,
  input logic [CNT_W-1:0] reject_cnt
);
  // R9
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);

  // R4
  ts_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> !ts_valid);

  // R5
  accept_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |-> (accept_cnt == CNT_W'($past(accept_cnt) + 1'b1)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ts_valid);

  // R10
  disarmed_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(accept_cnt));

  // R2
  reject_accept_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(reject_cnt) && !$stable(accept_cnt)));
endmodule

bind trig_strobe_gen trig_strobe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .busy(busy), .strobe(strobe),
  .ts_valid(ts_valid), .accept_cnt(accept_cnt), .reject_cnt(reject_cnt)
);

// File: tb/trig_strobe_gen_tb.sv
`timescale 1ns/1ps
module trig_strobe_gen_tb;
  localparam int TS_W = 16, CNT_W = 8, TMR_W = 8, FLT_W = 4;

  typedef struct packed {
    logic             pol;
    logic [FLT_W-1:0] m;
    logic [TMR_W-1:0] d;
    logic [TMR_W-1:0] w;
    logic [7:0]       len;
    logic             acc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3, 8'd0, 8'd1, 8'd5, 1'b1},
    '{1'b0, 4'd3, 8'd2, 8'd4, 8'd3, 1'b1},
    '{1'b0, 4'd3, 8'd2, 8'd4, 8'd2, 1'b0},
    '{1'b1, 4'd1, 8'd5, 8'd3, 8'd1, 1'b1},
    '{1'b1, 4'd4, 8'd1, 8'd2, 8'd3, 1'b0},
    '{1'b0, 4'd0, 8'd0, 8'd0, 8'd2, 1'b1},
    '{1'b1, 4'd2, 8'd7, 8'd1, 8'd6, 1'b1},
    '{1'b0, 4'd5, 8'd3, 8'd6, 8'd5, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, trig_in, cfg_we, cfg_pol, cfg_arm;
  logic [FLT_W-1:0] cfg_min_stable;
  logic [TMR_W-1:0] cfg_delay, cfg_width, delay_rb, width_rb;
  logic [TS_W-1:0]  timebase = '0;
  logic [TS_W-1:0]  ts_value;
  logic             ts_valid, strobe, armed, busy;
  logic [CNT_W-1:0] accept_cnt, reject_cnt, drop_cnt;

  always @(posedge clk) timebase <= timebase + 1'b1;

  trig_strobe_gen #(
    .SYNC_STAGES(2), .TS_W(TS_W), .CNT_W(CNT_W), .TMR_W(TMR_W), .FLT_W(FLT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .timebase(timebase),
    .cfg_we(cfg_we), .cfg_pol(cfg_pol), .cfg_arm(cfg_arm),
    .cfg_min_stable(cfg_min_stable), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
    .delay_rb(delay_rb), .width_rb(width_rb), .ts_value(ts_value),
    .ts_valid(ts_valid), .strobe(strobe), .armed(armed), .busy(busy),
    .accept_cnt(accept_cnt), .reject_cnt(reject_cnt), .drop_cnt(drop_cnt)
  );

  int checks = 0, errors = 0;
  int cyc = 0, tsv_n = 0, rise_n = 0, tsv_cyc = 0, rise_cyc = 0, fall_cyc = 0, busy_viol = 0;
  logic [TS_W-1:0] last_ts = '0;
  logic prev_strobe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ts_valid) begin tsv_n++; tsv_cyc = cyc; last_ts = ts_value; end
      if (strobe && !prev_strobe) begin rise_n++; rise_cyc = cyc; end
      if (!strobe && prev_strobe) fall_cyc = cyc;
      if (strobe && !busy) busy_viol++;
    end
    prev_strobe = strobe;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic pol, input logic arm, input logic [FLT_W-1:0] m,
                     input logic [TMR_W-1:0] d, input logic [TMR_W-1:0] w);
    @(negedge clk);
    cfg_pol = pol; cfg_arm = arm; cfg_min_stable = m; cfg_delay = d; cfg_width = w;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic pol, input int len, output logic [TS_W-1:0] t0);
    @(negedge clk);
    trig_in = ~pol;
    t0 = timebase;
    repeat (len) @(negedge clk);
    trig_in = pol;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TS_W-1:0] t0;
    int a0, r0, d0, tv0, rs0;
    rst_n = 1'b0; trig_in = 1'b0; cfg_we = 1'b0; cfg_pol = 1'b0; cfg_arm = 1'b0;
    cfg_min_stable = '0; cfg_delay = '0; cfg_width = '0;
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R11 reset state
    chk(accept_cnt == 0 && reject_cnt == 0 && drop_cnt == 0, "R11 counters", accept_cnt + reject_cnt + drop_cnt, 0);
    chk(!strobe && !busy && !armed && !ts_valid, "R11 status", {strobe, busy, armed, ts_valid}, 0);
    chk(delay_rb == 0 && width_rb == 0 && ts_value == 0, "R11 readback/ts", delay_rb + width_rb + ts_value, 0);

    // R8 readback
    cfg(1'b0, 1'b1, 4'd2, 8'hA5, 8'h3C);
    chk(delay_rb == 8'hA5, "R8 delay readback", delay_rb, 8'hA5);
    chk(width_rb == 8'h3C, "R8 width readback", width_rb, 8'h3C);
    chk(armed == 1'b1, "R9 armed follows arm flag", armed, 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cfg(v.pol, 1'b1, v.m, v.d, v.w);
      @(negedge clk) trig_in = v.pol;
      idle(20);
      a0 = accept_cnt; r0 = reject_cnt; tv0 = tsv_n; rs0 = rise_n;
      pulse(v.pol, int'(v.len), t0);
      idle(60);
      if (v.acc) begin
        chk(accept_cnt == CNT_W'(a0 + 1), "R5 accept count", accept_cnt, a0 + 1);
        chk(tsv_n == tv0 + 1, "R4 one ts_valid", tsv_n, tv0 + 1);
        chk(last_ts == t0, "R4 timestamp value", last_ts, t0);
        chk(reject_cnt == CNT_W'(r0), "R1 no reject on stable pulse", reject_cnt, r0);
        if (v.pol) chk(accept_cnt == CNT_W'(a0 + 1), "R3 falling edge accepted", accept_cnt, a0 + 1);
        if (v.w != 0) begin
          chk(rise_n == rs0 + 1, "R6 strobe fired", rise_n, rs0 + 1);
          chk(rise_cyc - tsv_cyc == int'(v.d), "R6 strobe delay", rise_cyc - tsv_cyc, v.d);
          chk(fall_cyc - rise_cyc == int'(v.w), "R7 strobe width", fall_cyc - rise_cyc, v.w);
        end else begin
          chk(rise_n == rs0, "R7 zero width suppresses strobe", rise_n, rs0);
        end
      end else begin
        chk(reject_cnt == CNT_W'(r0 + 1), "R2 reject count", reject_cnt, r0 + 1);
        chk(accept_cnt == CNT_W'(a0), "R2 no accept on glitch", accept_cnt, a0);
        chk(tsv_n == tv0, "R2 no timestamp on glitch", tsv_n, tv0);
        chk(rise_n == rs0, "R2 no strobe on glitch", rise_n, rs0);
      end
    end

    // R3 inactive direction ignored
    cfg(1'b0, 1'b1, 4'd1, 8'd0, 8'd1);
    @(negedge clk) trig_in = 1'b0;
    idle(20);
    cfg(1'b1, 1'b1, 4'd1, 8'd0, 8'd1);
    idle(5);
    a0 = accept_cnt; d0 = drop_cnt; r0 = reject_cnt; rs0 = rise_n;
    @(negedge clk) trig_in = 1'b1;
    idle(20);
    chk(accept_cnt == CNT_W'(a0) && drop_cnt == CNT_W'(d0) && reject_cnt == CNT_W'(r0),
        "R3 rising ignored when falling selected", accept_cnt, a0);
    chk(rise_n == rs0, "R3 no strobe on inactive edge", rise_n, rs0);
    @(negedge clk) trig_in = 1'b0;
    idle(20);
    chk(accept_cnt == CNT_W'(a0 + 1), "R3 falling edge taken", accept_cnt, a0 + 1);

    // R10 disarmed drop
    cfg(1'b0, 1'b0, 4'd1, 8'd0, 8'd2);
    idle(20);
    a0 = accept_cnt; d0 = drop_cnt; tv0 = tsv_n; rs0 = rise_n;
    pulse(1'b0, 3, t0);
    idle(30);
    chk(drop_cnt == CNT_W'(d0 + 1), "R10 drop while disarmed", drop_cnt, d0 + 1);
    chk(accept_cnt == CNT_W'(a0) && tsv_n == tv0, "R10 no accept while disarmed", accept_cnt, a0);
    chk(rise_n == rs0, "R10 no strobe while disarmed", rise_n, rs0);
    chk(armed == 1'b0, "R9 armed low", armed, 0);

    // R10 busy drop, R9 busy covers strobe
    cfg(1'b0, 1'b1, 4'd1, 8'd20, 8'd10);
    idle(10);
    a0 = accept_cnt; d0 = drop_cnt; rs0 = rise_n;
    pulse(1'b0, 3, t0);
    idle(8);
    chk(busy == 1'b1, "R9 busy during delay", busy, 1);
    pulse(1'b0, 3, t0);
    idle(60);
    chk(drop_cnt == CNT_W'(d0 + 1), "R10 drop while busy", drop_cnt, d0 + 1);
    chk(accept_cnt == CNT_W'(a0 + 1), "R10 only first accepted", accept_cnt, a0 + 1);
    chk(rise_n == rs0 + 1, "R10 single strobe", rise_n, rs0 + 1);
    chk(busy == 1'b0, "R9 busy clears", busy, 0);
    chk(busy_viol == 0, "R9 strobe only while busy", busy_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule